// File: doc/BRIEF.md
# Instruction TLB translation unit

This block turns the virtual address of an instruction fetch into a physical address. Translations live in a fully associative table. Each entry carries the following fields:

- a valid bit
- a virtual page number
- an address-space number
- a physical page number
- a four-bit execute-read permission mask with one bit per processor mode

A refill agent loads entries through a fill port. The slot written by a fill comes from a round-robin pointer. Running counters record hits, misses and access violations, so that the surrounding core can report them.

A fetch request carries three things: the virtual address, a flag that marks it as already physical, and the current mode and address-space number. The current mode and address-space number come from the control inputs and are sampled when the request is accepted. The block has two bypass paths that skip the table:

- Physical requests are formatted as physical addresses.
- Requests that fall into the superpage window are formatted the same way, and only in kernel mode.

Any other request is looked up in the table. It then receives one of these results:

- a translated address with no fault
- a miss
- an access violation
- a machine check, when the translated address has bits set above the implemented physical width

A three-state controller sequences each request:

- **IDLE**: the block is ready. The IDLE-to-LOOKUP transition is taken when a request is presented. Otherwise IDLE holds.
- **LOOKUP**: the table is searched and the result is computed. LOOKUP-to-RESPOND is unconditional.
- **RESPOND**: the result is presented for one cycle. RESPOND-to-IDLE is unconditional.

Top module: `ifetch_tlb`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, all three counters read 0, and no table entry is valid, so every lookup misses.
- R2: A request is accepted on a clock edge where both `req_valid` and `req_ready` are 1. `resp_valid` is then 1 for exactly one cycle, two edges after acceptance. `req_ready` is 0 during the two cycles in between, and requests presented while it is 0 are ignored.
- R3: An entry matches only when it is valid, its page number equals `req_va[47:13]`, and its address-space number equals the sampled `cur_asn`. When several entries match, the lowest index wins.
- R4: On a permitted hit, `resp_fault` is 0 (none) and `resp_pa` is `{ppn, req_va[12:2], 2'b00}`. The hit counter increments by one.
- R5: When no entry matches, `resp_fault` is 1 (miss) and `resp_pa` is 0. The miss counter increments by one.
- R6: On a hit, bit `mode` of the entry's permission mask is checked, where the modes are kernel=0, executive=1, supervisor=2 and user=3. If that bit is 0, `resp_fault` is 2 (access violation) and `resp_pa` is 0. The violation counter increments and the hit counter does not change.
- R7: A non-physical request with `req_va[47:41] == 7'b1111110` bypasses the table. In kernel mode it returns the formatted address with fault 0. In any other mode it returns fault 2 with `resp_pa` 0, and the violation counter increments.
- R8: The formatted address is built from `req_va[43:0]`. Bits 43:40 are forced to 1 when bit 40 is 1, and cleared otherwise. Bits 47:44 are always 0. A request with `req_phys` set uses this format in every mode, with fault 0 and no counter change.
- R9: A permitted hit whose address has any bit in 47:44 set returns fault 3 (machine check) with that address on `resp_pa`. The hit counter still increments.
- R10: Each fill writes the slot at the replacement pointer and advances the pointer, which wraps from 47 back to 0. A fill on the edge where a lookup is evaluated is not yet visible to that lookup.
- R11: Mode and address-space number are sampled at acceptance. Later changes do not affect that request's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Fetch translation request |
| req_ready | output | 1 | Block is in IDLE and accepts a request |
| req_va | input | 48 | Fetch virtual address |
| req_phys | input | 1 | Address is already physical |
| cur_mode | input | 2 | Current processor mode |
| cur_asn | input | 8 | Current address-space number |
| fill_valid | input | 1 | Write one table entry |
| fill_vpn | input | 35 | Virtual page number of the new entry |
| fill_asn | input | 8 | Address-space number of the new entry |
| fill_ppn | input | 35 | Physical page number of the new entry |
| fill_xre | input | 4 | Execute-read permission mask, one bit per mode |
| resp_valid | output | 1 | Result valid, one-cycle pulse |
| resp_pa | output | 48 | Physical address |
| resp_fault | output | 2 | 0 none, 1 miss, 2 access violation, 3 machine check |
| hit_count | output | 32 | Permitted table hits |
| miss_count | output | 32 | Table misses |
| acv_count | output | 32 | Access violations |

## Verification
A wrong internal state shows up quickly at the ports.

- **Controller state.** A corrupted state shows in `req_ready` or `resp_valid` within one or two cycles of the next request.
- **Table contents.** A wrong valid bit, tag or permission mask shows only when a lookup reaches that entry. It then appears on `resp_fault` or `resp_pa` two edges after acceptance, and on the matching counter at the same time.
- **Replacement pointer.** A pointer that skips or wraps wrongly is silent until a later lookup finds a surviving or overwritten entry that should not be there. The bench therefore fills past the table size and probes old entries.

The reference model in the bench recomputes every result and counter on every clock.

// File: rtl/itlb_pkg.sv
package itlb_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_MISS = 2'd1,
        FLT_ACV  = 2'd2,
        FLT_MCHK = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_LOOKUP  = 2'd1,
        S_RESPOND = 2'd2
    } tlb_state_e;

    localparam int CNT_HIT  = 0;
    localparam int CNT_MISS = 1;
    localparam int CNT_ACV  = 2;
    localparam int NUM_CNT  = 3;

endpackage

// File: rtl/itlb_table.sv
module itlb_table #(
    parameter int ENTRIES = 48,
    parameter int VPN_W   = 35,
    parameter int PPN_W   = 35,
    parameter int ASN_W   = 8,
    parameter int PERM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASN_W-1:0]  fill_asn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PERM_W-1:0] fill_xre,
    input  logic [VPN_W-1:0]  look_vpn,
    input  logic [ASN_W-1:0]  look_asn,
    output logic              look_hit,
    output logic [PPN_W-1:0]  look_ppn,
    output logic [PERM_W-1:0] look_xre
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [ASN_W-1:0]   asn_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];
    logic [PERM_W-1:0]  xre_q [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [PTR_W-1:0]   rr_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (fill_valid) begin
            rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
        end
    end

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    valid_q[g] <= 1'b0;
                end else if (fill_valid && rr_ptr == PTR_W'(g)) begin
                    valid_q[g] <= 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (fill_valid && rr_ptr == PTR_W'(g)) begin
                    vpn_q[g] <= fill_vpn;
                    asn_q[g] <= fill_asn;
                    ppn_q[g] <= fill_ppn;
                    xre_q[g] <= fill_xre;
                end
            end

            assign match[g] = valid_q[g] && (vpn_q[g] == look_vpn) && (asn_q[g] == look_asn);
        end
    endgenerate

    // lowest index wins: scan downward so the last assignment is the lowest match
    always_comb begin
        look_hit = 1'b0;
        look_ppn = '0;
        look_xre = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                look_hit = 1'b1;
                look_ppn = ppn_q[i];
                look_xre = xre_q[i];
            end
        end
    end

    assert_ptr_range_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        rr_ptr <= LAST);

    assert_ptr_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |=> $stable(rr_ptr));

endmodule

// File: rtl/itlb_phys_fmt.sv
module itlb_phys_fmt #(
    parameter int OUT_W   = 48,
    parameter int PA_W    = 44,
    parameter int UNC_BIT = 40
) (
    input  logic [OUT_W-1:0] va,
    output logic [OUT_W-1:0] pa
);
    localparam logic [OUT_W-1:0] IMPL_MASK = (OUT_W'(1) << PA_W) - OUT_W'(1);
    localparam logic [OUT_W-1:0] LOW_MASK  = (OUT_W'(1) << UNC_BIT) - OUT_W'(1);
    localparam logic [OUT_W-1:0] EXT_MASK  = IMPL_MASK & ~LOW_MASK;

    logic [OUT_W-1:0] masked;

    always_comb begin
        masked = va & IMPL_MASK;
        if (masked[UNC_BIT]) begin
            pa = masked | EXT_MASK;
        end else begin
            pa = masked & LOW_MASK;
        end
    end

endmodule

// File: rtl/itlb_counters.sv
module itlb_counters import itlb_pkg::*; #(
    parameter int CNT_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CNT-1:0]            inc,
    output logic [NUM_CNT-1:0][CNT_W-1:0] count
);
    genvar g;
    generate
        for (g = 0; g < NUM_CNT; g++) begin : g_cnt
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    count[g] <= '0;
                end else if (inc[g]) begin
                    count[g] <= count[g] + 1'b1;
                end
            end
        end
    endgenerate

    assert_single_event_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        $countones(inc) <= 1);

endmodule

// File: rtl/ifetch_tlb.sv
module ifetch_tlb import itlb_pkg::*; #(
    parameter int ENTRIES  = 48,
    parameter int VA_W     = 48,
    parameter int PA_W     = 44,
    parameter int PG_SHIFT = 13,
    parameter int ASN_W    = 8,
    parameter int MODE_W   = 2,
    parameter int CNT_W    = 32,
    parameter int UNC_BIT  = 40,
    parameter int SP_W     = 7,
    parameter logic [SP_W-1:0] SP_TAG = 7'h7e
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [VA_W-1:0]                req_va,
    input  logic                           req_phys,
    input  logic [MODE_W-1:0]              cur_mode,
    input  logic [ASN_W-1:0]               cur_asn,
    input  logic                           fill_valid,
    input  logic [VA_W-PG_SHIFT-1:0]       fill_vpn,
    input  logic [ASN_W-1:0]               fill_asn,
    input  logic [VA_W-PG_SHIFT-1:0]       fill_ppn,
    input  logic [(1<<MODE_W)-1:0]         fill_xre,
    output logic                           resp_valid,
    output logic [VA_W-1:0]                resp_pa,
    output logic [1:0]                     resp_fault,
    output logic [CNT_W-1:0]               hit_count,
    output logic [CNT_W-1:0]               miss_count,
    output logic [CNT_W-1:0]               acv_count
);
    localparam int VPN_W  = VA_W - PG_SHIFT;
    localparam int PPN_W  = VA_W - PG_SHIFT;
    localparam int PERM_W = 1 << MODE_W;

    tlb_state_e state, state_nx;

    logic [VA_W-1:0]   cap_va;
    logic              cap_phys;
    logic [MODE_W-1:0] cap_mode;
    logic [ASN_W-1:0]  cap_asn;

    logic              tbl_hit;
    logic [PPN_W-1:0]  tbl_ppn;
    logic [PERM_W-1:0] tbl_xre;
    logic [VA_W-1:0]   fmt_pa;
    logic [VA_W-1:0]   hit_pa;
    logic              sp_region;

    fault_e            eval_fault;
    logic [VA_W-1:0]   eval_pa;
    logic [NUM_CNT-1:0] eval_inc;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;

    itlb_table #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W),
        .ASN_W   (ASN_W),
        .PERM_W  (PERM_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_valid (fill_valid),
        .fill_vpn   (fill_vpn),
        .fill_asn   (fill_asn),
        .fill_ppn   (fill_ppn),
        .fill_xre   (fill_xre),
        .look_vpn   (cap_va[VA_W-1:PG_SHIFT]),
        .look_asn   (cap_asn),
        .look_hit   (tbl_hit),
        .look_ppn   (tbl_ppn),
        .look_xre   (tbl_xre)
    );

    itlb_phys_fmt #(
        .OUT_W   (VA_W),
        .PA_W    (PA_W),
        .UNC_BIT (UNC_BIT)
    ) u_fmt (
        .va (cap_va),
        .pa (fmt_pa)
    );

    itlb_counters #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cnt_inc),
        .count (cnt_val)
    );

    assign hit_count  = cnt_val[CNT_HIT];
    assign miss_count = cnt_val[CNT_MISS];
    assign acv_count  = cnt_val[CNT_ACV];
    assign req_ready  = (state == S_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (req_valid) state_nx = S_LOOKUP;
            S_LOOKUP:  state_nx = S_RESPOND;
            S_RESPOND: state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // result evaluation from the captured request
    assign sp_region = (cap_va[VA_W-1 -: SP_W] == SP_TAG);
    assign hit_pa    = {tbl_ppn, cap_va[PG_SHIFT-1:2], 2'b00};

    always_comb begin
        eval_fault = FLT_NONE;
        eval_pa    = '0;
        eval_inc   = '0;
        if (cap_phys) begin
            eval_pa = fmt_pa;
        end else if (sp_region) begin
            if (cap_mode == '0) begin
                eval_pa = fmt_pa;
            end else begin
                eval_fault        = FLT_ACV;
                eval_inc[CNT_ACV] = 1'b1;
            end
        end else if (!tbl_hit) begin
            eval_fault         = FLT_MISS;
            eval_inc[CNT_MISS] = 1'b1;
        end else if (!tbl_xre[cap_mode]) begin
            eval_fault        = FLT_ACV;
            eval_inc[CNT_ACV] = 1'b1;
        end else begin
            eval_pa           = hit_pa;
            eval_inc[CNT_HIT] = 1'b1;
            if (|hit_pa[VA_W-1:PA_W]) begin
                eval_fault = FLT_MCHK;
            end
        end
    end

    assign cnt_inc = (state == S_LOOKUP) ? eval_inc : '0;

    // outputs and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_pa    <= '0;
            resp_fault <= FLT_NONE;
            cap_va     <= '0;
            cap_phys   <= 1'b0;
            cap_mode   <= '0;
            cap_asn    <= '0;
        end else begin
            resp_valid <= (state == S_LOOKUP);
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        cap_va   <= req_va;
                        cap_phys <= req_phys;
                        cap_mode <= cur_mode;
                        cap_asn  <= cur_asn;
                    end
                end
                S_LOOKUP: begin
                    resp_pa    <= eval_pa;
                    resp_fault <= eval_fault;
                end
                default: ;
            endcase
        end
    end

    assert_resp_pulse_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_resp_after_accept_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid && req_ready, 2));

    assert_miss_zero_pa_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault == FLT_MISS) |-> (resp_pa == '0));

    assert_miss_count_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault == FLT_MISS) |-> (miss_count == $past(miss_count) + 1'b1));

    assert_acv_count_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault == FLT_ACV) |-> (acv_count == $past(acv_count) + 1'b1));

    assert_acv_no_hit_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault == FLT_ACV) |-> $stable(hit_count));

    assert_mchk_high_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault == FLT_MCHK) |-> (|resp_pa[VA_W-1:PA_W]));

    assert_none_in_range_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault == FLT_NONE) |-> (resp_pa[VA_W-1:PA_W] == '0));

endmodule

// File: tb/test_ifetch_tlb.sv
module test_ifetch_tlb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_va = '0;
    logic        req_phys = 1'b0;
    logic [1:0]  cur_mode = 2'd0;
    logic [7:0]  cur_asn = 8'd0;
    logic        fill_valid = 1'b0;
    logic [34:0] fill_vpn = '0;
    logic [7:0]  fill_asn = '0;
    logic [34:0] fill_ppn = '0;
    logic [3:0]  fill_xre = '0;
    logic        resp_valid;
    logic [47:0] resp_pa;
    logic [1:0]  resp_fault;
    logic [31:0] hit_count, miss_count, acv_count;

    always #5 clk = ~clk;

    ifetch_tlb i_ifetch_tlb (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_phys(req_phys), .cur_mode(cur_mode), .cur_asn(cur_asn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asn(fill_asn),
        .fill_ppn(fill_ppn), .fill_xre(fill_xre),
        .resp_valid(resp_valid), .resp_pa(resp_pa), .resp_fault(resp_fault),
        .hit_count(hit_count), .miss_count(miss_count), .acv_count(acv_count)
    );

    int    n_checks = 0;
    int    n_bad = 0;
    string cur_tag = "R1";
    bit    done = 0;

    // ---------------- reference model ----------------
    bit          m_valid [48];
    logic [34:0] m_vpn [48];
    logic [7:0]  m_asn [48];
    logic [34:0] m_ppn [48];
    logic [3:0]  m_xre [48];
    int          m_ptr;
    int          m_state;
    logic [47:0] m_cva;
    bit          m_cphys;
    logic [1:0]  m_cmode;
    logic [7:0]  m_casn;
    bit          m_rvalid;
    logic [47:0] m_rpa;
    int          m_rfault;
    int          m_hits, m_miss, m_acv;

    function automatic logic [47:0] fmt(input logic [47:0] va);
        logic [47:0] m;
        m = va & 48'h0FFF_FFFF_FFFF;
        if (m[40]) m = m | 48'h0F00_0000_0000;
        else       m = m & 48'h00FF_FFFF_FFFF;
        return m;
    endfunction

    task automatic model_eval();
        int idx;
        idx = -1;
        m_rpa = 48'd0;
        m_rfault = 0;
        if (m_cphys) begin
            m_rpa = fmt(m_cva);
        end else if (m_cva[47:41] == 7'b1111110) begin
            if (m_cmode == 2'd0) m_rpa = fmt(m_cva);
            else begin m_rfault = 2; m_acv++; end
        end else begin
            for (int i = 0; i < 48; i++)
                if (idx < 0 && m_valid[i] && m_vpn[i] == m_cva[47:13] && m_asn[i] == m_casn)
                    idx = i;
            if (idx < 0) begin
                m_rfault = 1; m_miss++;
            end else if (m_xre[idx][m_cmode] == 1'b0) begin
                m_rfault = 2; m_acv++;
            end else begin
                m_rpa = (48'(m_ppn[idx]) << 13) + 48'(m_cva[12:0] & 13'h1FFC);
                m_hits++;
                if (m_rpa[47:44] != 4'd0) m_rfault = 3;
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 48; i++) m_valid[i] = 0;
            m_ptr = 0; m_state = 0; m_rvalid = 0;
            m_hits = 0; m_miss = 0; m_acv = 0;
        end else begin
            m_rvalid = 0;
            case (m_state)
                0: if (req_valid) begin
                       m_cva = req_va; m_cphys = req_phys;
                       m_cmode = cur_mode; m_casn = cur_asn;
                       m_state = 1;
                   end
                1: begin model_eval(); m_rvalid = 1; m_state = 2; end
                default: m_state = 0;
            endcase
            if (fill_valid) begin
                m_valid[m_ptr] = 1; m_vpn[m_ptr] = fill_vpn; m_asn[m_ptr] = fill_asn;
                m_ppn[m_ptr] = fill_ppn; m_xre[m_ptr] = fill_xre;
                m_ptr = (m_ptr == 47) ? 0 : m_ptr + 1;
            end
        end
    end

    // ---------------- comparison ----------------
    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(req_ready == (m_state == 0), "req_ready", 64'(req_ready), 64'(m_state == 0));
            check(resp_valid == m_rvalid, "resp_valid", 64'(resp_valid), 64'(m_rvalid));
            check(hit_count == 32'(m_hits), "hit_count", 64'(hit_count), 64'(m_hits));
            check(miss_count == 32'(m_miss), "miss_count", 64'(miss_count), 64'(m_miss));
            check(acv_count == 32'(m_acv), "acv_count", 64'(acv_count), 64'(m_acv));
            if (m_rvalid) begin
                check(resp_fault == 2'(m_rfault), "resp_fault", 64'(resp_fault), 64'(m_rfault));
                check(resp_pa == m_rpa, "resp_pa", 64'(resp_pa), 64'(m_rpa));
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic fill(input logic [34:0] vpn, input logic [7:0] asn, input logic [34:0] ppn, input logic [3:0] xre);
        @(negedge clk);
        fill_valid = 1; fill_vpn = vpn; fill_asn = asn; fill_ppn = ppn; fill_xre = xre;
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic send(input string tag, input logic [47:0] va, input bit phys, input logic [1:0] mode, input logic [7:0] asn);
        @(negedge clk);
        cur_tag = tag;
        req_valid = 1; req_va = va; req_phys = phys; cur_mode = mode; cur_asn = asn;
        @(negedge clk);
        req_valid = 0;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [47:0] mkva(input logic [34:0] vpn, input logic [12:0] off);
        return {vpn, off};
    endfunction

    localparam logic [34:0] VA_A = 35'h1234;
    localparam logic [34:0] VA_B = 35'h2222;
    localparam logic [34:0] VA_C = 35'h3333;

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_bad++;
        $display("FAIL watchdog run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_tag = "R1";
        repeat (2) @(negedge clk);
        send("R1", mkva(VA_A, 13'h0010), 0, 2'd0, 8'd1);      // empty table misses
        send("R5", mkva(VA_B, 13'h0123), 0, 2'd3, 8'd4);

        fill(VA_A, 8'd1, 35'h456, 4'b1111);                 // slot 0
        fill(VA_A, 8'd2, 35'h789, 4'b0001);                 // slot 1, kernel only
        fill(VA_A, 8'd1, 35'hABC, 4'b1111);                 // slot 2, duplicate
        fill(VA_B, 8'd1, 35'h4_0000_0001, 4'b1111);         // slot 3, out of range
        fill(VA_C, 8'd7, 35'h111, 4'b0100);                 // slot 4, supervisor only

        send("R4", mkva(VA_A, 13'h1ABF), 0, 2'd3, 8'd1);    // slot 0 wins over slot 2
        send("R3", mkva(VA_A, 13'h0007), 0, 2'd0, 8'd2);
        send("R3", mkva(VA_A, 13'h0007), 0, 2'd0, 8'd3);    // asn mismatch
        send("R6", mkva(VA_A, 13'h0100), 0, 2'd3, 8'd2);
        send("R6", mkva(VA_C, 13'h0100), 0, 2'd1, 8'd7);
        send("R6", mkva(VA_C, 13'h0FFE), 0, 2'd2, 8'd7);
        send("R9", mkva(VA_B, 13'h0ABC), 0, 2'd1, 8'd1);
        send("R7", 48'hFC00_1234_5678, 0, 2'd0, 8'd0);
        send("R7", 48'hFD12_3456_789A, 0, 2'd0, 8'd9);
        send("R7", 48'hFD12_3456_789A, 0, 2'd3, 8'd9);
        send("R8", 48'hABCD_EF01_2345, 1, 2'd3, 8'd0);
        send("R8", 48'h7EE0_1111_2223, 1, 2'd2, 8'd0);

        // R11: mode and asn change while the request is in flight
        @(negedge clk);
        cur_tag = "R11";
        req_valid = 1; req_va = mkva(VA_A, 13'h0040); req_phys = 0; cur_mode = 2'd3; cur_asn = 8'd2;
        @(negedge clk);
        req_valid = 0; cur_mode = 2'd0; cur_asn = 8'd1;
        repeat (3) @(negedge clk);

        // R2: back-to-back requests while busy are ignored
        @(negedge clk);
        cur_tag = "R2";
        req_valid = 1; cur_mode = 2'd0; cur_asn = 8'd1; req_phys = 0;
        for (int k = 0; k < 4; k++) begin
            req_va = mkva((k == 0) ? VA_A : VA_C, 13'(k * 4));
            @(negedge clk);
        end
        req_valid = 0;
        repeat (4) @(negedge clk);

        // R10: a fill on the evaluation edge is not seen by that lookup
        @(negedge clk);
        cur_tag = "R10";
        req_valid = 1; req_va = mkva(35'h5555, 13'h0008); cur_mode = 2'd0; cur_asn = 8'd5;
        @(negedge clk);
        req_valid = 0;
        fill_valid = 1; fill_vpn = 35'h5555; fill_asn = 8'd5; fill_ppn = 35'h999; fill_xre = 4'b1111;
        @(negedge clk);
        fill_valid = 0;
        repeat (3) @(negedge clk);
        send("R10", mkva(35'h5555, 13'h0008), 0, 2'd0, 8'd5);

        // R10: wrap the pointer, overwriting slots 0 and 1
        for (int k = 0; k < 44; k++) fill(35'h10000 + 35'(k), 8'd3, 35'(k), 4'b1000);
        send("R10", mkva(VA_A, 13'h0004), 0, 2'd0, 8'd2);   // slot 1 gone: miss
        send("R10", mkva(VA_A, 13'h0004), 0, 2'd0, 8'd1);   // slot 2 now lowest match
        send("R10", mkva(35'h10000 + 35'd43, 13'h0C0C), 0, 2'd3, 8'd3);
        send("R10", mkva(35'h10000 + 35'd0, 13'h0004), 0, 2'd3, 8'd3);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule